// File: doc/BRIEF.md
# Aspect-Ratio Dual-Port RAM Output Stage

This block is a true dual-port synchronous RAM. It holds 16,384 data bits and 2,048 parity bits. Each port picks its own word width at elaboration time from 1, 2, 4, 9 or 18 bits. Both ports see the same 14-bit linear address space. A narrow port uses every address bit. A wider port ignores the low address bits that fall inside one of its words.

Reads land in a per-port read-data latch one cycle after the address is presented. An optional pipeline register can follow the latch. It has an active-high clock enable and adds one more cycle.

Two synchronous reset inputs per port load a per-port 36-bit initial value, one into the latch and one into the register. These resets never touch the storage array. A parameter decides whether the register reset overrides the register enable or only acts while the enable is high. Another pair of parameters sets the polarity of each reset input.

Top module: `aspect_dpram`

## Requirements
- R1: A port of width W (1, 2, 4, 9 or 18) decodes address bits [13:k], where k is 0, 1, 2, 3 or 4 respectively. The lower k address bits have no effect, so the port is 16384, 8192, 4096, 2048 or 1024 words deep.
- R2: Data bit j of a port with D data bits (D = 1, 2, 4, 8, 16) at address a is linear data bit (a with its low log2(D) bits cleared) + j. Both ports share this bit space, and a write changes only the D bits it addresses.
- R3: A 9-bit port carries 8 data bits (bits [7:0]) plus parity bit 0 at parity index a[13:3]. An 18-bit port carries 16 data bits plus parity bits 1:0 at parity indices a[13:4]*2 + {0,1}. Ports of width 1, 2 and 4 have no parity: their parity inputs are ignored and their parity outputs read 0.
- R4: Data and parity input bits above a port's width are ignored. Output bits above its width are always 0.
- R5: When en is 1 at a clock edge, the latch takes the word stored at the address before any write of that edge (read-first). When en is 0, the latch holds its value.
- R6: With the output register enabled, the register loads the latch value only at edges where ce is 1. The output is the register, so read data appears two edges after the address. With the register disabled, the output is the latch.
- R7: An active latch reset at a clock edge loads the latch with the port's initial value, whatever en is.
- R8: An active register reset loads the register with the initial value. If RST_OVER_CE is 1, it acts regardless of ce. If RST_OVER_CE is 0, it acts only at edges where ce is 1 and otherwise the register holds.
- R9: The initial value takes the data from INIT[D-1:0] and the parity from INIT[D+P-1:D], where P is the parity count. Example: INIT 36'h1_2345_6789 on a 9-bit port gives data 8'h89 and parity 1.
- R10: Neither reset changes stored contents, and neither disturbs a write made on the other port in the same cycle.
- R11: LAT_RST_HIGH and REG_RST_HIGH set each reset input to active-high (1) or active-low (0).
- R12: When both ports write the same stored bit at the same edge, port B's value is kept.
- R13: At power-up each port's output equals its initial value, and the storage holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable (qualified by a_en) |
| a_ce | input | 1 | Port A output register clock enable |
| a_rst_lat | input | 1 | Port A latch reset |
| a_rst_reg | input | 1 | Port A output register reset |
| a_addr | input | 14 | Port A linear address |
| a_din | input | 16 | Port A write data, low bits used |
| a_dinp | input | 2 | Port A write parity, low bits used |
| a_dout | output | 16 | Port A read data |
| a_doutp | output | 2 | Port A read parity |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable (qualified by b_en) |
| b_ce | input | 1 | Port B output register clock enable |
| b_rst_lat | input | 1 | Port B latch reset |
| b_rst_reg | input | 1 | Port B output register reset |
| b_addr | input | 14 | Port B linear address |
| b_din | input | 16 | Port B write data, low bits used |
| b_dinp | input | 2 | Port B write parity, low bits used |
| b_dout | output | 16 | Port B read data |
| b_doutp | output | 2 | Port B read parity |

## Verification
Latch contents, latch resets and register resets are all due at the output one rising edge after the inputs that cause them. Read data through the register is due two edges after the address, with the middle edge depending on ce. A write is visible to either port's read starting from the next edge.

The bench drives every input on the falling edge. Its behavioural model advances on the same rising edge as the design. Both outputs are compared on the following falling edge, so each expected value lines up with the exact cycle in which the design's output must change. Three configurations cover all five widths, both register settings, both priorities and both reset polarities.

// File: rtl/aspect_dpram_pkg.sv
package aspect_dpram_pkg;
  localparam int ADDR_W = 14;
  localparam int WORD_W = 16;
  localparam int WPAR_W = 2;
  localparam int INIT_W = 36;

  function automatic int lg2(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  function automatic int data_w(input int width);
    case (width)
      9:       return 8;
      18:      return 16;
      default: return width;
    endcase
  endfunction

  function automatic int par_w(input int width);
    case (width)
      9:       return 1;
      18:      return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/aspect_dpram_lane.sv
module aspect_dpram_lane
  import aspect_dpram_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [WORD_W-1:0]                 din,
  input  logic [WPAR_W-1:0]                 dinp,
  input  logic [WORD_W-1:0]                 rd_word,
  input  logic [WPAR_W-1:0]                 rd_wpar,
  output logic [ADDR_W-lg2(WORD_W)-1:0]     word_idx,
  output logic [WORD_W-1:0]                 wmask,
  output logic [WORD_W-1:0]                 wdata,
  output logic [WPAR_W-1:0]                 pmask,
  output logic [WPAR_W-1:0]                 pdata,
  output logic [WORD_W-1:0]                 rdata,
  output logic [WPAR_W-1:0]                 rpar
);
  localparam int OFF_W = lg2(WORD_W);
  localparam int DW    = data_w(WIDTH);
  localparam int PW    = par_w(WIDTH);
  localparam int LG    = lg2(DW);
  localparam logic [WORD_W-1:0] DMASK    = WORD_W'((64'd1 << DW) - 64'd1);
  localparam logic [WPAR_W-1:0] PMASK    = WPAR_W'((64'd1 << PW) - 64'd1);
  localparam logic [OFF_W-1:0]  OFF_KEEP = OFF_W'(~((64'd1 << LG) - 64'd1));

  logic [OFF_W-1:0] off;
  logic             poff;

  // bit offset of this port's word inside one stored row
  assign off      = addr[OFF_W-1:0] & OFF_KEEP;
  assign poff     = off[OFF_W-1];
  assign word_idx = addr[ADDR_W-1:OFF_W];

  assign wmask = DMASK << off;
  assign wdata = (din & DMASK) << off;
  assign pmask = PMASK << poff;
  assign pdata = (dinp & PMASK) << poff;

  assign rdata = (rd_word >> off) & DMASK;
  assign rpar  = (rd_wpar >> poff) & PMASK;
endmodule

// File: rtl/aspect_dpram_core.sv
module aspect_dpram_core
  import aspect_dpram_pkg::*;
#(
  parameter int IDX_W = ADDR_W - lg2(WORD_W)
) (
  input  logic              clk,
  input  logic              a_wr,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [WORD_W-1:0] a_wmask,
  input  logic [WORD_W-1:0] a_wdata,
  input  logic [WPAR_W-1:0] a_pmask,
  input  logic [WPAR_W-1:0] a_pdata,
  output logic [WORD_W-1:0] a_rword,
  output logic [WPAR_W-1:0] a_rwpar,
  input  logic              b_wr,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [WORD_W-1:0] b_wmask,
  input  logic [WORD_W-1:0] b_wdata,
  input  logic [WPAR_W-1:0] b_pmask,
  input  logic [WPAR_W-1:0] b_pdata,
  output logic [WORD_W-1:0] b_rword,
  output logic [WPAR_W-1:0] b_rwpar
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem_d [DEPTH];
  logic [WPAR_W-1:0] mem_p [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = '0;
      mem_p[i] = '0;
    end
  end

  // per-bit writes; port B is applied last so it wins a shared bit
  always_ff @(posedge clk) begin
    for (int i = 0; i < WORD_W; i++) begin
      if (a_wr && a_wmask[i]) mem_d[a_idx][i] <= a_wdata[i];
      if (b_wr && b_wmask[i]) mem_d[b_idx][i] <= b_wdata[i];
    end
    for (int i = 0; i < WPAR_W; i++) begin
      if (a_wr && a_pmask[i]) mem_p[a_idx][i] <= a_pdata[i];
      if (b_wr && b_pmask[i]) mem_p[b_idx][i] <= b_pdata[i];
    end
  end

  assign a_rword = mem_d[a_idx];
  assign a_rwpar = mem_p[a_idx];
  assign b_rword = mem_d[b_idx];
  assign b_rwpar = mem_p[b_idx];
endmodule

// File: rtl/aspect_dpram_outstage.sv
module aspect_dpram_outstage
  import aspect_dpram_pkg::*;
#(
  parameter int                WIDTH        = 9,
  parameter bit                USE_REG      = 1'b1,
  parameter bit                RST_OVER_CE  = 1'b1,
  parameter bit                LAT_RST_HIGH = 1'b1,
  parameter bit                REG_RST_HIGH = 1'b1,
  parameter logic [INIT_W-1:0] INIT         = '0
) (
  input  logic              clk,
  input  logic              en,
  input  logic              ce,
  input  logic              rst_lat,
  input  logic              rst_reg,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [WPAR_W-1:0] rd_par,
  output logic [WORD_W-1:0] dout,
  output logic [WPAR_W-1:0] doutp
);
  localparam int SLOT_W = WORD_W + WPAR_W;
  localparam int DW     = data_w(WIDTH);
  localparam int PW     = par_w(WIDTH);
  localparam logic [WORD_W-1:0] INIT_D = WORD_W'(INIT & ((INIT_W'(1) << DW) - INIT_W'(1)));
  localparam logic [WPAR_W-1:0] INIT_P = WPAR_W'((INIT >> DW) & ((INIT_W'(1) << PW) - INIT_W'(1)));
  localparam logic [SLOT_W-1:0] INIT_V = {INIT_P, INIT_D};

  logic              lat_on;
  logic              reg_on;
  logic [SLOT_W-1:0] lat_q = INIT_V;
  logic [SLOT_W-1:0] out_v;

  assign lat_on = (rst_lat == LAT_RST_HIGH);
  assign reg_on = (rst_reg == REG_RST_HIGH);

  always_ff @(posedge clk) begin
    if (lat_on)  lat_q <= INIT_V;
    else if (en) lat_q <= {rd_par, rd_data};
  end

  generate
    if (USE_REG) begin : g_reg
      logic [SLOT_W-1:0] reg_q = INIT_V;
      always_ff @(posedge clk) begin
        if (reg_on && (RST_OVER_CE || ce)) reg_q <= INIT_V;
        else if (ce)                       reg_q <= lat_q;
      end
      assign out_v = reg_q;
    end else begin : g_noreg
      logic unused_reg_pins;
      assign unused_reg_pins = ^{ce, rst_reg};
      assign out_v = lat_q;
    end
  endgenerate

  assign dout  = out_v[WORD_W-1:0];
  assign doutp = out_v[SLOT_W-1:WORD_W];
endmodule

// File: rtl/aspect_dpram.sv
module aspect_dpram
  import aspect_dpram_pkg::*;
#(
  parameter int                A_WIDTH      = 9,
  parameter int                B_WIDTH      = 18,
  parameter bit                A_USE_REG    = 1'b1,
  parameter bit                B_USE_REG    = 1'b0,
  parameter bit                RST_OVER_CE  = 1'b1,
  parameter bit                LAT_RST_HIGH = 1'b1,
  parameter bit                REG_RST_HIGH = 1'b1,
  parameter logic [INIT_W-1:0] A_INIT       = '0,
  parameter logic [INIT_W-1:0] B_INIT       = '0
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic              a_ce,
  input  logic              a_rst_lat,
  input  logic              a_rst_reg,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [WORD_W-1:0] a_din,
  input  logic [WPAR_W-1:0] a_dinp,
  output logic [WORD_W-1:0] a_dout,
  output logic [WPAR_W-1:0] a_doutp,
  input  logic              b_en,
  input  logic              b_we,
  input  logic              b_ce,
  input  logic              b_rst_lat,
  input  logic              b_rst_reg,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [WORD_W-1:0] b_din,
  input  logic [WPAR_W-1:0] b_dinp,
  output logic [WORD_W-1:0] b_dout,
  output logic [WPAR_W-1:0] b_doutp
);
  localparam int IDX_W = ADDR_W - lg2(WORD_W);

  logic [IDX_W-1:0]  a_idx,   b_idx;
  logic [WORD_W-1:0] a_wmask, b_wmask, a_wdata, b_wdata;
  logic [WPAR_W-1:0] a_pmask, b_pmask, a_pdata, b_pdata;
  logic [WORD_W-1:0] a_rword, b_rword, a_rdata, b_rdata;
  logic [WPAR_W-1:0] a_rwpar, b_rwpar, a_rpar,  b_rpar;

  aspect_dpram_lane #(.WIDTH(A_WIDTH)) u_lane_a (
    .addr(a_addr), .din(a_din), .dinp(a_dinp),
    .rd_word(a_rword), .rd_wpar(a_rwpar),
    .word_idx(a_idx), .wmask(a_wmask), .wdata(a_wdata),
    .pmask(a_pmask), .pdata(a_pdata),
    .rdata(a_rdata), .rpar(a_rpar)
  );

  aspect_dpram_lane #(.WIDTH(B_WIDTH)) u_lane_b (
    .addr(b_addr), .din(b_din), .dinp(b_dinp),
    .rd_word(b_rword), .rd_wpar(b_rwpar),
    .word_idx(b_idx), .wmask(b_wmask), .wdata(b_wdata),
    .pmask(b_pmask), .pdata(b_pdata),
    .rdata(b_rdata), .rpar(b_rpar)
  );

  aspect_dpram_core #(.IDX_W(IDX_W)) u_core (
    .clk(clk),
    .a_wr(a_en & a_we), .a_idx(a_idx), .a_wmask(a_wmask), .a_wdata(a_wdata),
    .a_pmask(a_pmask), .a_pdata(a_pdata), .a_rword(a_rword), .a_rwpar(a_rwpar),
    .b_wr(b_en & b_we), .b_idx(b_idx), .b_wmask(b_wmask), .b_wdata(b_wdata),
    .b_pmask(b_pmask), .b_pdata(b_pdata), .b_rword(b_rword), .b_rwpar(b_rwpar)
  );

  aspect_dpram_outstage #(
    .WIDTH(A_WIDTH), .USE_REG(A_USE_REG), .RST_OVER_CE(RST_OVER_CE),
    .LAT_RST_HIGH(LAT_RST_HIGH), .REG_RST_HIGH(REG_RST_HIGH), .INIT(A_INIT)
  ) u_out_a (
    .clk(clk), .en(a_en), .ce(a_ce), .rst_lat(a_rst_lat), .rst_reg(a_rst_reg),
    .rd_data(a_rdata), .rd_par(a_rpar), .dout(a_dout), .doutp(a_doutp)
  );

  aspect_dpram_outstage #(
    .WIDTH(B_WIDTH), .USE_REG(B_USE_REG), .RST_OVER_CE(RST_OVER_CE),
    .LAT_RST_HIGH(LAT_RST_HIGH), .REG_RST_HIGH(REG_RST_HIGH), .INIT(B_INIT)
  ) u_out_b (
    .clk(clk), .en(b_en), .ce(b_ce), .rst_lat(b_rst_lat), .rst_reg(b_rst_reg),
    .rd_data(b_rdata), .rd_par(b_rpar), .dout(b_dout), .doutp(b_doutp)
  );
endmodule

// File: rtl/aspect_dpram_chk.sv
module aspect_dpram_chk
  import aspect_dpram_pkg::*;
#(
  parameter int                WIDTH        = 9,
  parameter bit                USE_REG      = 1'b1,
  parameter bit                RST_OVER_CE  = 1'b1,
  parameter bit                LAT_RST_HIGH = 1'b1,
  parameter bit                REG_RST_HIGH = 1'b1,
  parameter logic [INIT_W-1:0] INIT         = '0
) (
  input logic              clk,
  input logic              en,
  input logic              ce,
  input logic              rst_lat,
  input logic              rst_reg,
  input logic [WORD_W-1:0] dout,
  input logic [WPAR_W-1:0] doutp
);
  localparam int DW = data_w(WIDTH);
  localparam int PW = par_w(WIDTH);
  localparam logic [WORD_W+WPAR_W-1:0] EXP_INIT =
    {WPAR_W'((INIT >> DW) & ((INIT_W'(1) << PW) - INIT_W'(1))),
     WORD_W'(INIT & ((INIT_W'(1) << DW) - INIT_W'(1)))};

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  logic lat_on, reg_on;
  assign lat_on = (rst_lat == LAT_RST_HIGH);
  assign reg_on = (rst_reg == REG_RST_HIGH);

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    ((dout >> DW) == '0) && ((doutp >> PW) == '0));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (!USE_REG && !en && !lat_on) |=> $stable({doutp, dout}));

  // R6
  reg_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (USE_REG && !ce && !(reg_on && RST_OVER_CE)) |=> $stable({doutp, dout}));

  // R7
  latch_rst_chk: assert property (@(posedge clk) disable iff (!armed)
    (!USE_REG && lat_on) |=> ({doutp, dout} == EXP_INIT));

  // R8
  reg_rst_chk: assert property (@(posedge clk) disable iff (!armed)
    (USE_REG && reg_on && (RST_OVER_CE || ce)) |=> ({doutp, dout} == EXP_INIT));
endmodule

bind aspect_dpram aspect_dpram_chk #(
  .WIDTH(A_WIDTH), .USE_REG(A_USE_REG), .RST_OVER_CE(RST_OVER_CE),
  .LAT_RST_HIGH(LAT_RST_HIGH), .REG_RST_HIGH(REG_RST_HIGH), .INIT(A_INIT)
) u_chk_a (
  .clk(clk), .en(a_en), .ce(a_ce), .rst_lat(a_rst_lat), .rst_reg(a_rst_reg),
  .dout(a_dout), .doutp(a_doutp)
);

bind aspect_dpram aspect_dpram_chk #(
  .WIDTH(B_WIDTH), .USE_REG(B_USE_REG), .RST_OVER_CE(RST_OVER_CE),
  .LAT_RST_HIGH(LAT_RST_HIGH), .REG_RST_HIGH(REG_RST_HIGH), .INIT(B_INIT)
) u_chk_b (
  .clk(clk), .en(b_en), .ce(b_ce), .rst_lat(b_rst_lat), .rst_reg(b_rst_reg),
  .dout(b_dout), .doutp(b_doutp)
);

// File: tb/aspect_dpram_bench.sv
module aspect_dpram_ref #(
  parameter int          A_WIDTH      = 9,
  parameter int          B_WIDTH      = 18,
  parameter bit          A_USE_REG    = 1'b1,
  parameter bit          B_USE_REG    = 1'b0,
  parameter bit          RST_OVER_CE  = 1'b1,
  parameter bit          LAT_RST_HIGH = 1'b1,
  parameter bit          REG_RST_HIGH = 1'b1,
  parameter logic [35:0] A_INIT       = '0,
  parameter logic [35:0] B_INIT       = '0
) (
  input  logic        clk,
  input  logic        a_en, a_we, a_ce, a_rst_lat, a_rst_reg,
  input  logic [13:0] a_addr,
  input  logic [15:0] a_din,
  input  logic [1:0]  a_dinp,
  output logic [15:0] a_dout,
  output logic [1:0]  a_doutp,
  input  logic        b_en, b_we, b_ce, b_rst_lat, b_rst_reg,
  input  logic [13:0] b_addr,
  input  logic [15:0] b_din,
  input  logic [1:0]  b_dinp,
  output logic [15:0] b_dout,
  output logic [1:0]  b_doutp
);
  bit [15:0] md [1024];
  bit [1:0]  mp [1024];
  logic [17:0] lat [2];
  logic [17:0] rg  [2];

  function automatic int dbits(input int w);
    return (w % 9 == 0) ? (w / 9) * 8 : w;
  endfunction
  function automatic int pbits(input int w);
    return (w % 9 == 0) ? w / 9 : 0;
  endfunction

  function automatic logic [17:0] initv(input int w, input logic [35:0] iv);
    logic [17:0] r;
    r = '0;
    for (int j = 0; j < dbits(w); j++) r[j] = iv[j];
    for (int j = 0; j < pbits(w); j++) r[16+j] = iv[dbits(w)+j];
    return r;
  endfunction

  function automatic logic [17:0] rd(input int w, input int ad);
    logic [17:0] r;
    int base, pb;
    r = '0;
    base = ad - (ad % dbits(w));
    pb = base / 8;
    for (int j = 0; j < dbits(w); j++) r[j] = md[(base+j)/16][(base+j)%16];
    for (int j = 0; j < pbits(w); j++) r[16+j] = mp[(pb+j)/2][(pb+j)%2];
    return r;
  endfunction

  task automatic wr(input int w, input int ad, input logic [15:0] d, input logic [1:0] p);
    int base, pb;
    base = ad - (ad % dbits(w));
    pb = base / 8;
    for (int j = 0; j < dbits(w); j++) md[(base+j)/16][(base+j)%16] = d[j];
    for (int j = 0; j < pbits(w); j++) mp[(pb+j)/2][(pb+j)%2] = p[j];
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin md[i] = '0; mp[i] = '0; end
    lat[0] = initv(A_WIDTH, A_INIT); rg[0] = lat[0];
    lat[1] = initv(B_WIDTH, B_INIT); rg[1] = lat[1];
  end

  always @(posedge clk) begin
    logic [17:0] ra, rb;
    ra = rd(A_WIDTH, int'(a_addr));
    rb = rd(B_WIDTH, int'(b_addr));
    if (A_USE_REG) begin
      if ((a_rst_reg == REG_RST_HIGH) && (RST_OVER_CE || a_ce)) rg[0] = initv(A_WIDTH, A_INIT);
      else if (a_ce) rg[0] = lat[0];
    end
    if (B_USE_REG) begin
      if ((b_rst_reg == REG_RST_HIGH) && (RST_OVER_CE || b_ce)) rg[1] = initv(B_WIDTH, B_INIT);
      else if (b_ce) rg[1] = lat[1];
    end
    if (a_rst_lat == LAT_RST_HIGH) lat[0] = initv(A_WIDTH, A_INIT);
    else if (a_en) lat[0] = ra;
    if (b_rst_lat == LAT_RST_HIGH) lat[1] = initv(B_WIDTH, B_INIT);
    else if (b_en) lat[1] = rb;
    if (a_en && a_we) wr(A_WIDTH, int'(a_addr), a_din, a_dinp);
    if (b_en && b_we) wr(B_WIDTH, int'(b_addr), b_din, b_dinp);
  end

  always_comb begin
    {a_doutp, a_dout} = A_USE_REG ? rg[0] : lat[0];
    {b_doutp, b_dout} = B_USE_REG ? rg[1] : lat[1];
  end
endmodule

module aspect_dpram_bench;
  localparam time CLK_PERIOD = 10;
  localparam int  NCFG = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        a_en = 0, a_we = 0, a_ce = 0, a_rst_lat = 0, a_rst_reg = 0;
  logic        b_en = 0, b_we = 0, b_ce = 0, b_rst_lat = 0, b_rst_reg = 0;
  logic [13:0] a_addr = '0, b_addr = '0;
  logic [15:0] a_din = '0, b_din = '0;
  logic [1:0]  a_dinp = '0, b_dinp = '0;

  logic [15:0] dut_ad [NCFG], dut_bd [NCFG], ref_ad [NCFG], ref_bd [NCFG];
  logic [1:0]  dut_ap [NCFG], dut_bp [NCFG], ref_ap [NCFG], ref_bp [NCFG];

  int    tests = 0;
  int    fails = 0;
  string cur_req = "R13";
  bit    done = 0;

  // cfg0: 9-bit registered A, 18-bit unregistered B, reset overrides ce, active-high
  aspect_dpram #(.A_WIDTH(9), .B_WIDTH(18), .A_USE_REG(1), .B_USE_REG(0), .RST_OVER_CE(1),
    .LAT_RST_HIGH(1), .REG_RST_HIGH(1), .A_INIT(36'h1_2345_6789), .B_INIT(36'h0_000A_BCDE))
  u_aspect_dpram (.*, .a_dout(dut_ad[0]), .a_doutp(dut_ap[0]), .b_dout(dut_bd[0]), .b_doutp(dut_bp[0]));
  aspect_dpram_ref #(.A_WIDTH(9), .B_WIDTH(18), .A_USE_REG(1), .B_USE_REG(0), .RST_OVER_CE(1),
    .LAT_RST_HIGH(1), .REG_RST_HIGH(1), .A_INIT(36'h1_2345_6789), .B_INIT(36'h0_000A_BCDE))
  u_ref0 (.*, .a_dout(ref_ad[0]), .a_doutp(ref_ap[0]), .b_dout(ref_bd[0]), .b_doutp(ref_bp[0]));

  // cfg1: 1-bit A, 4-bit registered B, reset gated by ce, both resets active-low (R11)
  aspect_dpram #(.A_WIDTH(1), .B_WIDTH(4), .A_USE_REG(0), .B_USE_REG(1), .RST_OVER_CE(0),
    .LAT_RST_HIGH(0), .REG_RST_HIGH(0), .A_INIT(36'h1), .B_INIT(36'hA))
  u_aspect_dpram_c1 (.*, .a_rst_lat(~a_rst_lat), .a_rst_reg(~a_rst_reg),
    .b_rst_lat(~b_rst_lat), .b_rst_reg(~b_rst_reg),
    .a_dout(dut_ad[1]), .a_doutp(dut_ap[1]), .b_dout(dut_bd[1]), .b_doutp(dut_bp[1]));
  aspect_dpram_ref #(.A_WIDTH(1), .B_WIDTH(4), .A_USE_REG(0), .B_USE_REG(1), .RST_OVER_CE(0),
    .LAT_RST_HIGH(0), .REG_RST_HIGH(0), .A_INIT(36'h1), .B_INIT(36'hA))
  u_ref1 (.*, .a_rst_lat(~a_rst_lat), .a_rst_reg(~a_rst_reg),
    .b_rst_lat(~b_rst_lat), .b_rst_reg(~b_rst_reg),
    .a_dout(ref_ad[1]), .a_doutp(ref_ap[1]), .b_dout(ref_bd[1]), .b_doutp(ref_bp[1]));

  // cfg2: 2-bit registered A, 1-bit B, register reset active-low
  aspect_dpram #(.A_WIDTH(2), .B_WIDTH(1), .A_USE_REG(1), .B_USE_REG(0), .RST_OVER_CE(1),
    .LAT_RST_HIGH(1), .REG_RST_HIGH(0), .A_INIT(36'h2), .B_INIT(36'h0))
  u_aspect_dpram_c2 (.*, .a_rst_reg(~a_rst_reg), .b_rst_reg(~b_rst_reg),
    .a_dout(dut_ad[2]), .a_doutp(dut_ap[2]), .b_dout(dut_bd[2]), .b_doutp(dut_bp[2]));
  aspect_dpram_ref #(.A_WIDTH(2), .B_WIDTH(1), .A_USE_REG(1), .B_USE_REG(0), .RST_OVER_CE(1),
    .LAT_RST_HIGH(1), .REG_RST_HIGH(0), .A_INIT(36'h2), .B_INIT(36'h0))
  u_ref2 (.*, .a_rst_reg(~a_rst_reg), .b_rst_reg(~b_rst_reg),
    .a_dout(ref_ad[2]), .a_doutp(ref_ap[2]), .b_dout(ref_bd[2]), .b_doutp(ref_bp[2]));

  task automatic check(input string req, input string what,
                       input logic [17:0] got, input logic [17:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < NCFG; k++) begin
      check(cur_req, $sformatf("cfg%0d port A", k), {dut_ap[k], dut_ad[k]}, {ref_ap[k], ref_ad[k]});
      check(cur_req, $sformatf("cfg%0d port B", k), {dut_bp[k], dut_bd[k]}, {ref_bp[k], ref_bd[k]});
    end
  endtask

  function automatic bit pct(input int p);
    return $urandom_range(99) < p;
  endfunction

  task automatic run(input string tag, input int cycles, input int p_we, input int p_en,
                     input int p_ce, input int p_lat, input int p_reg, input int span,
                     input bit same_addr);
    cur_req = tag;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_all();
      a_en = pct(p_en); b_en = pct(p_en);
      a_we = pct(p_we); b_we = pct(p_we);
      a_ce = pct(p_ce); b_ce = pct(p_ce);
      a_rst_lat = pct(p_lat); b_rst_lat = pct(p_lat);
      a_rst_reg = pct(p_reg); b_rst_reg = pct(p_reg);
      a_addr = 14'($urandom_range(span - 1));
      b_addr = same_addr ? a_addr : 14'($urandom_range(span - 1));
      a_din = 16'($urandom); b_din = 16'($urandom);
      a_dinp = 2'($urandom); b_dinp = 2'($urandom);
    end
  endtask

  initial begin
    @(negedge clk);
    // R13: power-up outputs hold the initial values
    cur_req = "R13";
    compare_all();
    // R9: hand-derived initial values for cfg0 and cfg1
    check("R9", "cfg0 A init", {dut_ap[0], dut_ad[0]}, {2'b01, 16'h0089});
    check("R9", "cfg0 B init", {dut_bp[0], dut_bd[0]}, {2'b10, 16'hBCDE});
    check("R9", "cfg1 B init", {dut_bp[1], dut_bd[1]}, {2'b00, 16'h000A});
    check("R9", "cfg2 A init", {dut_ap[2], dut_ad[2]}, {2'b00, 16'h0002});
    run("R1",  600, 70, 100, 100, 0, 0, 16384, 0);
    run("R2",  600, 60, 100, 100, 0, 0, 64, 0);
    run("R3",  400, 50, 100, 100, 0, 0, 256, 0);
    run("R4",  200, 50, 100, 100, 0, 0, 32, 0);
    run("R5",  500, 30, 50, 100, 0, 0, 64, 0);
    run("R6",  500, 30, 80, 40, 0, 0, 64, 0);
    run("R7",  400, 30, 60, 70, 25, 0, 64, 0);
    run("R8",  500, 30, 80, 50, 0, 30, 64, 0);
    run("R9",  300, 30, 80, 60, 30, 30, 64, 0);
    run("R10", 400, 80, 100, 60, 40, 40, 32, 0);
    run("R10", 200, 0, 100, 100, 0, 0, 32, 0);
    run("R11", 400, 30, 70, 50, 35, 35, 64, 0);
    run("R12", 400, 80, 100, 100, 0, 0, 32, 1);
    run("R5",  8, 0, 0, 100, 0, 0, 16, 0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule